// File: doc/BRIEF.md
# Video line and vblank sequencer

The sequencer turns the system clock into scanline timing for the video side of a chip. A programmable divider counts system clocks per line and emits a one-cycle hsync tick at the end of each line period. A line counter advances on each tick. At a region-dependent line it strobes the start of vertical blanking. When the count reaches the frame total it returns to zero, raises the frame interrupt and emits a frame-done strobe. Independently, an audio-update strobe is issued once every 32 lines, and this cadence runs straight through frame boundaries.

Two region modes are supported. The 60 Hz mode uses 263 lines per frame with blanking from line 240. The 50 Hz mode uses 313 lines with blanking from line 256. The integrator programs the line period as clock frequency / (frame rate × lines per frame). Region and period are captured once after reset and again at every frame wrap, so a frame always runs with one consistent geometry. The divider restarts exactly on each line boundary, so no clocks are lost or gained and line timing does not drift.

Top module: `video_line_seq`

## Requirements
- R1: While reset is asserted, every strobe output is 0 and `line_o` is 0.
- R2: After reset is released, the first `hsync_tick_o` pulse comes P+1 clocks later: one clock to capture the configuration, then P clocks. Each later pulse comes exactly P clocks after the previous one. P is the captured line period, and a captured value of 0 acts as 1.
- R3: `line_o` changes only in a cycle where `hsync_tick_o` is 1. In that cycle it becomes the previous value plus one, or 0 on a frame wrap.
- R4: With `region_i`=0 (60 Hz) a frame has 263 lines: after line 262 the next tick shows line 0. With `region_i`=1 (50 Hz) a frame has 313 lines: after line 312 the next tick shows line 0.
- R5: `vblank_start_o` pulses for one cycle, together with the tick on which `line_o` becomes 240 (60 Hz) or 256 (50 Hz). It is 0 at all other times.
- R6: `frame_irq_o` and `frame_done_o` pulse for one cycle together with the tick on which `line_o` wraps to 0. They never pulse at vblank start.
- R7: `audio_upd_o` pulses together with every 32nd hsync tick counted from reset. The count continues unchanged across frame wraps and region changes.
- R8: `region_i` is sampled only on the first clock after reset and on the clock of a frame-wrap tick. Changes at any other time have no effect on the current frame.
- R9: `line_period_i` is sampled at the same two points as `region_i`. A mid-frame change leaves the tick spacing unchanged until the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| region_i | input | 1 | Region select: 0 = 60 Hz, 1 = 50 Hz |
| line_period_i | input | 16 | Line period in system clocks |
| hsync_tick_o | output | 1 | One-cycle pulse at each line boundary |
| vblank_start_o | output | 1 | One-cycle pulse when the first blanking line begins |
| frame_irq_o | output | 1 | Frame interrupt (interrupt bit 0) pulse on frame wrap |
| frame_done_o | output | 1 | Frame-done strobe to the video side on frame wrap |
| audio_upd_o | output | 1 | One-cycle pulse every 32 lines |
| line_o | output | 9 | Current line number within the frame |

## Verification
In 50 Hz mode, line 256 is a multiple of 32. On the first frame after reset, the vblank strobe and the audio strobe therefore land on the same tick, and the bench starts in that mode to force the collision. The frame wrap can also coincide with an audio strobe, because the audio cadence carries over between frames. Random period and region changes move the alignment so that such coincidences arise. A tick-level reference model in the bench predicts every strobe independently on every tick. It flags a missing, extra or merged pulse in any cycle where two functions meet.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic {
    RGN_60HZ = 1'b0,
    RGN_50HZ = 1'b1
  } region_e;
endpackage

// File: rtl/vls_line_divider.sv
module vls_line_divider #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                tick_o
);
  logic [PERIOD_W-1:0] phase_q, phase_d, last_c;
  logic                phase_en;

  always_comb begin
    last_c   = (period_i == '0) ? '0 : period_i - 1'b1;
    tick_o   = run_i && (phase_q == last_c);
    phase_en = 1'b1;
    if (!run_i || tick_o) phase_d = '0;
    else                  phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (phase_en) phase_q <= phase_d;
  end
endmodule

// File: rtl/vls_line_counter.sv
module vls_line_counter #(
  parameter int LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [LINE_W-1:0] total_i,
  input  logic [LINE_W-1:0] vbl_i,
  output logic [LINE_W-1:0] line_o,
  output logic              wrap_o,
  output logic              vbl_stb_o,
  output logic              frame_stb_o
);
  logic [LINE_W-1:0] line_q, line_d, nxt_c;
  logic              vbl_d;

  always_comb begin
    nxt_c  = line_q + 1'b1;
    wrap_o = tick_i && (nxt_c == total_i);
    line_d = wrap_o ? '0 : nxt_c;
    vbl_d  = tick_i && !wrap_o && (nxt_c == vbl_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q      <= '0;
      vbl_stb_o   <= 1'b0;
      frame_stb_o <= 1'b0;
    end else begin
      if (tick_i) line_q <= line_d;
      vbl_stb_o   <= vbl_d;
      frame_stb_o <= wrap_o;
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/vls_audio_pacer.sv
module vls_audio_pacer #(
  parameter int AUDIO_LINES = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic audio_stb_o
);
  localparam int ACC_W = (AUDIO_LINES > 1) ? $clog2(AUDIO_LINES) : 1;
  localparam logic [ACC_W-1:0] ACC_LAST = ACC_W'(AUDIO_LINES - 1);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic             hit_c;

  always_comb begin
    hit_c = tick_i && (acc_q == ACC_LAST);
    acc_d = hit_c ? '0 : acc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      audio_stb_o <= 1'b0;
    end else begin
      if (tick_i) acc_q <= acc_d;
      audio_stb_o <= hit_c;
    end
  end
endmodule

// File: rtl/video_line_seq.sv
module video_line_seq
  import vls_pkg::*;
#(
  parameter int PERIOD_W    = 16,
  parameter int LINES_60    = 263,
  parameter int LINES_50    = 313,
  parameter int VBL_60      = 240,
  parameter int VBL_50      = 256,
  parameter int AUDIO_LINES = 32,
  localparam int LINE_W     = $clog2(((LINES_50 > LINES_60) ? LINES_50 : LINES_60) + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                region_i,
  input  logic [PERIOD_W-1:0] line_period_i,
  output logic                hsync_tick_o,
  output logic                vblank_start_o,
  output logic                frame_irq_o,
  output logic                frame_done_o,
  output logic                audio_upd_o,
  output logic [LINE_W-1:0]   line_o
);
  logic                load_pend_q;
  logic [PERIOD_W-1:0] period_q;
  region_e             region_q;
  logic                tick_c, wrap_c, cfg_load, hsync_q, frame_stb;
  logic [LINE_W-1:0]   total_c, vbl_c;

  always_comb begin
    total_c  = (region_q == RGN_50HZ) ? LINE_W'(LINES_50) : LINE_W'(LINES_60);
    vbl_c    = (region_q == RGN_50HZ) ? LINE_W'(VBL_50)   : LINE_W'(VBL_60);
    cfg_load = load_pend_q || wrap_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_pend_q <= 1'b1;
      period_q    <= '0;
      region_q    <= RGN_60HZ;
      hsync_q     <= 1'b0;
    end else begin
      load_pend_q <= 1'b0;
      hsync_q     <= tick_c;
      if (cfg_load) begin
        period_q <= line_period_i;
        region_q <= region_e'(region_i);
      end
    end
  end

  vls_line_divider #(.PERIOD_W(PERIOD_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (!load_pend_q),
    .period_i (period_q),
    .tick_o   (tick_c)
  );

  vls_line_counter #(.LINE_W(LINE_W)) u_lines (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_c),
    .total_i     (total_c),
    .vbl_i       (vbl_c),
    .line_o      (line_o),
    .wrap_o      (wrap_c),
    .vbl_stb_o   (vblank_start_o),
    .frame_stb_o (frame_stb)
  );

  vls_audio_pacer #(.AUDIO_LINES(AUDIO_LINES)) u_audio (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_c),
    .audio_stb_o (audio_upd_o)
  );

  assign hsync_tick_o = hsync_q;
  assign frame_irq_o  = frame_stb;
  assign frame_done_o = frame_stb;
endmodule

// File: rtl/vls_checker.sv
module vls_checker #(
  parameter int LINE_W   = 9,
  parameter int LINES_60 = 263,
  parameter int LINES_50 = 313,
  parameter int VBL_60   = 240,
  parameter int VBL_50   = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hsync_tick_o,
  input logic              vblank_start_o,
  input logic              frame_irq_o,
  input logic              frame_done_o,
  input logic              audio_upd_o,
  input logic [LINE_W-1:0] line_o,
  input logic              region_q
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!hsync_tick_o && !vblank_start_o && !frame_irq_o && !audio_upd_o);
    end
  end

  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_tick_o |-> $stable(line_o));

  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync_tick_o && !frame_irq_o) |-> (line_o == $past(line_o) + 1'b1));

  a_r4_line_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (line_o < LINE_W'(LINES_50)) && (region_q || (line_o < LINE_W'(LINES_60)) || frame_irq_o || !hsync_tick_o || (line_o >= LINE_W'(VBL_60))));

  a_r5_vbl_line: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_start_o |-> hsync_tick_o && (line_o == (region_q ? LINE_W'(VBL_50) : LINE_W'(VBL_60))));

  a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq_o |-> hsync_tick_o && (line_o == '0) && frame_done_o && !vblank_start_o);

  a_r6_done_tracks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |-> frame_irq_o);

  a_r7_audio_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    audio_upd_o |-> hsync_tick_o);
endmodule

bind video_line_seq vls_checker #(
  .LINE_W   (LINE_W),
  .LINES_60 (LINES_60),
  .LINES_50 (LINES_50),
  .VBL_60   (VBL_60),
  .VBL_50   (VBL_50)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .hsync_tick_o   (hsync_tick_o),
  .vblank_start_o (vblank_start_o),
  .frame_irq_o    (frame_irq_o),
  .frame_done_o   (frame_done_o),
  .audio_upd_o    (audio_upd_o),
  .line_o         (line_o),
  .region_q       (region_q)
);

// File: tb/video_line_seq_test.sv
module video_line_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        region_i = 1'b1;
  logic [15:0] line_period_i = 16'd3;
  logic        hsync_tick_o, vblank_start_o, frame_irq_o, frame_done_o, audio_upd_o;
  logic [8:0]  line_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  video_line_seq uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .region_i       (region_i),
    .line_period_i  (line_period_i),
    .hsync_tick_o   (hsync_tick_o),
    .vblank_start_o (vblank_start_o),
    .frame_irq_o    (frame_irq_o),
    .frame_done_o   (frame_done_o),
    .audio_upd_o    (audio_upd_o),
    .line_o         (line_o)
  );

  function automatic int lines_of(bit rgn);
    return rgn ? 313 : 263;
  endfunction
  function automatic int vbl_of(bit rgn);
    return rgn ? 256 : 240;
  endfunction
  function automatic int eff_period(logic [15:0] p);
    return (p == 16'd0) ? 1 : int'(p);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  int  since, exp_int, m_line, m_acc, m_period, frames;
  bit  m_region;
  bit  forced;
  bit  saw_coincide;

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!hsync_tick_o && !vblank_start_o && !frame_irq_o && !frame_done_o && !audio_upd_o,
          "R1 strobes in reset", int'(hsync_tick_o), 0);
    check(line_o == 9'd0, "R1 line in reset", int'(line_o), 0);
    // model captures the configuration present at release
    m_region = region_i;
    m_period = eff_period(line_period_i);
    exp_int  = m_period + 1;
    m_line = 0; m_acc = 0; frames = 0; since = 0; forced = 1'b0; saw_coincide = 1'b0;
    rst_n = 1'b1;
    while (frames < 8) begin
      @(negedge clk);
      since++;
      if (hsync_tick_o) begin
        int  nl;
        bit  wrap, e_vbl, e_aud;
        check(since == exp_int, "R2 R9 tick spacing", since, exp_int);
        nl   = m_line + 1;
        wrap = (nl == lines_of(m_region));
        if (wrap) nl = 0;
        e_vbl = !wrap && (nl == vbl_of(m_region));
        e_aud = (m_acc == 31);
        m_acc = e_aud ? 0 : m_acc + 1;
        check(int'(line_o) == nl, wrap ? "R4 wrap to line 0" : "R3 line increment", int'(line_o), nl);
        check(vblank_start_o == e_vbl, "R5 vblank strobe", int'(vblank_start_o), int'(e_vbl));
        check(frame_irq_o == wrap, "R6 frame irq", int'(frame_irq_o), int'(wrap));
        check(frame_done_o == wrap, "R6 frame done", int'(frame_done_o), int'(wrap));
        check(audio_upd_o == e_aud, "R7 audio strobe", int'(audio_upd_o), int'(e_aud));
        if (e_aud && (e_vbl || wrap)) saw_coincide = 1'b1;
        if (wrap) begin
          // R8 R9: inputs present at the wrap edge take over
          m_region = region_i;
          m_period = eff_period(line_period_i);
          frames++;
        end
        m_line  = nl;
        exp_int = m_period;
        since   = 0;
      end else begin
        check(!vblank_start_o && !frame_irq_o && !frame_done_o && !audio_upd_o,
              "R5 R6 R7 no strobe without tick", int'(vblank_start_o | frame_irq_o | audio_upd_o), 0);
        check(int'(line_o) == m_line, "R3 line holds", int'(line_o), m_line);
      end
      if (since > 40) begin
        check(1'b0, "R2 watchdog tick missing", since, exp_int);
        break;
      end
      // stimulus after sampling
      if (frames == 2 && m_line > 10 && !forced) begin
        line_period_i = 16'd0;   // directed: period 0 acts as 1 (R9)
        region_i      = 1'b0;
        forced        = 1'b1;
      end else if (frames != 2 && ($urandom % 150) == 0) begin
        // R8 R9: mid-frame changes must wait for the wrap
        region_i      = 1'($urandom % 2);
        line_period_i = 16'($urandom % 5);
      end
    end
    check(saw_coincide, "R5 R7 coincident strobes seen", int'(saw_coincide), 1);
    check(frames == 8, "R4 frames completed", frames, 8);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule